// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the four processor condition flags (Zero, Negative, Unsigned overflow, Signed overflow) and decides whether a conditional branch is taken. When an instruction retires, the execution stage presents a flag result together with a class bit that says whether the instruction is flow control. Only non-flow-control instructions may change the flags. When a return from interrupt restores state, the flag field of the saved control word is reloaded in a single cycle.

A branch request carries a 5-bit condition selector. The unit evaluates that selector against the current flags. The Unsigned-overflow flag acts as a borrow after a subtraction or compare, so the unsigned and signed magnitude tests follow from the flags directly. The registered decision also gates the register update for a pre-decrement or post-increment branch target. That register changes only when the branch is taken, and a no-op written as a never-taken branch leaves everything alone.

Top module: `cond_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags, `br_taken` and `addr_upd_en`.
- R2: When `upd_valid` is 1 and `upd_is_flow` is 0, `flags` takes the value of `alu_flags` on the next clock edge. The bit encoding is bit 0 Zero (Zr), bit 1 Negative (Ng), bit 2 Unsigned overflow / borrow (Uo), bit 3 Signed overflow (So).
- R3: When `upd_valid` is 1 and `upd_is_flow` is 1, the flags do not change. This covers branch, call, return, return from interrupt, no-op and any write to the program counter.
- R4: The general selector codes are: 0 always, 1 never (this is also the no-op), 2 Zr set, 3 Zr clear, 4 Ng set, 5 Ng clear, 6 Uo set, 7 Uo clear, 8 So set, 9 So clear.
- R5: The equality and unsigned codes are: 10 equal (Zr), 11 not equal (!Zr), 12 unsigned greater (!(Uo|Zr)), 13 unsigned greater-or-equal (!Uo), 14 unsigned less (Uo), 15 unsigned less-or-equal (Uo|Zr). After a compare of D minus S, they match the unsigned relation of D to S.
- R6: The signed codes are: 18 signed less (So^Ng), 19 signed less-or-equal ((So^Ng)|Zr), 16 signed greater (the inverse of code 19), 17 signed greater-or-equal (the inverse of code 18). After a compare, they match the two's-complement relation of D to S.
- R7: Selector codes 20 to 31 are never taken.
- R8: `addr_upd_en` is 1 only when the branch is taken and `br_autoreg` was 1 with the request. In every other case it is 0.
- R9: `br_taken` and `addr_upd_en` are registered. They reflect the request accepted on the previous edge, evaluated with the flags held at that time, and they are 0 in any cycle that follows an edge with no request.
- R10: When `rti_valid` is 1, the flags load `rti_flags` on the next edge. This takes priority over an ALU update in the same cycle.
- R11: With neither `upd_valid` nor `rti_valid` asserted, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | An instruction retires with a flag result |
| upd_is_flow | input | 1 | The retiring instruction is flow control |
| alu_flags | input | 4 | Flag result {So,Uo,Ng,Zr} |
| rti_valid | input | 1 | Restore flags from the saved control word |
| rti_flags | input | 4 | Flag field of the saved control word |
| br_valid | input | 1 | Branch decision requested |
| br_cond | input | 5 | Branch condition selector |
| br_autoreg | input | 1 | Branch target uses pre-decrement or post-increment addressing |
| flags | output | 4 | Current flag register |
| br_taken | output | 1 | Registered branch decision |
| addr_upd_en | output | 1 | Registered gate for the address register update |

## Verification
The assertions assume the inputs are known and stable at each rising edge. They also assume that a branch decision reads the flags already registered, so a flag update in the same cycle as a request is not forwarded. The bench drives every input on the falling edge and changes the flags in separate cycles ahead of each request. It sweeps every flag value against every selector code, with the auto-addressing bit both off and on. Compare results are computed in 16-bit arithmetic and checked against the native signed and unsigned relations.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NFLAG = 4;
  localparam int F_ZR = 0;
  localparam int F_NG = 1;
  localparam int F_UO = 2;
  localparam int F_SO = 3;

  typedef enum logic [4:0] {
    C_ALW = 5'd0,  C_NEV = 5'd1,
    C_ZRS = 5'd2,  C_ZRC = 5'd3,
    C_NGS = 5'd4,  C_NGC = 5'd5,
    C_UOS = 5'd6,  C_UOC = 5'd7,
    C_SOS = 5'd8,  C_SOC = 5'd9,
    C_EQ  = 5'd10, C_NE  = 5'd11,
    C_UGT = 5'd12, C_UGE = 5'd13,
    C_ULT = 5'd14, C_ULE = 5'd15,
    C_SGT = 5'd16, C_SGE = 5'd17,
    C_SLT = 5'd18, C_SLE = 5'd19
  } cond_e;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic             upd_is_flow,
  input  logic [NFLAG-1:0] alu_flags,
  input  logic             rti_valid,
  input  logic [NFLAG-1:0] rti_flags,
  output logic [NFLAG-1:0] flags_q
);
  logic alu_wr;
  assign alu_wr = upd_valid && !upd_is_flow;

  for (genvar g = 0; g < NFLAG; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            flags_q[g] <= 1'b0;
      else if (rti_valid) flags_q[g] <= rti_flags[g];
      else if (alu_wr)    flags_q[g] <= alu_flags[g];
    end
  end

  AST_ALU_LOAD: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_is_flow && !rti_valid) |=> flags_q == $past(alu_flags)); // R2
  AST_FLOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_is_flow && !rti_valid) |=> $stable(flags_q)); // R3
  AST_RTI_WINS: assert property (@(posedge clk) disable iff (rst)
    rti_valid |=> flags_q == $past(rti_flags)); // R10
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && !rti_valid) |=> $stable(flags_q)); // R11
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
#(
  parameter int COND_W = 5
) (
  input  logic [NFLAG-1:0]  flags,
  input  logic [COND_W-1:0] cond,
  output logic              take
);
  logic zr, ng, uo, so, slt, sle;
  assign zr  = flags[F_ZR];
  assign ng  = flags[F_NG];
  assign uo  = flags[F_UO];
  assign so  = flags[F_SO];
  assign slt = so ^ ng;
  assign sle = slt | zr;

  always_comb begin
    unique case (cond)
      C_ALW:   take = 1'b1;
      C_NEV:   take = 1'b0;
      C_ZRS:   take = zr;
      C_ZRC:   take = !zr;
      C_NGS:   take = ng;
      C_NGC:   take = !ng;
      C_UOS:   take = uo;
      C_UOC:   take = !uo;
      C_SOS:   take = so;
      C_SOC:   take = !so;
      C_EQ:    take = zr;
      C_NE:    take = !zr;
      C_UGT:   take = !(uo | zr);
      C_UGE:   take = !uo;
      C_ULT:   take = uo;
      C_ULE:   take = uo | zr;
      C_SGT:   take = !sle;
      C_SGE:   take = !slt;
      C_SLT:   take = slt;
      C_SLE:   take = sle;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    if (cond == C_NEV || cond > C_SLE) begin
      AST_NEVER_CODES: assert (!take); // R7
    end
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cc_pkg::*;
#(
  parameter int COND_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic              upd_is_flow,
  input  logic [NFLAG-1:0]  alu_flags,
  input  logic              rti_valid,
  input  logic [NFLAG-1:0]  rti_flags,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  input  logic              br_autoreg,
  output logic [NFLAG-1:0]  flags,
  output logic              br_taken,
  output logic              addr_upd_en
);
  logic take_c;

  cc_flag_reg u_flags (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_is_flow(upd_is_flow), .alu_flags(alu_flags),
    .rti_valid(rti_valid), .rti_flags(rti_flags),
    .flags_q(flags)
  );

  cc_cond_eval #(.COND_W(COND_W)) u_eval (
    .flags(flags), .cond(br_cond), .take(take_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken    <= 1'b0;
      addr_upd_en <= 1'b0;
    end else begin
      br_taken    <= br_valid && take_c;
      addr_upd_en <= br_valid && take_c && br_autoreg;
    end
  end

  AST_GATE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    addr_upd_en |-> br_taken); // R8
  AST_GATE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_autoreg) |=> !addr_upd_en); // R8
  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> (!br_taken && !addr_upd_en)); // R9
  AST_ALW_TAKES: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == C_ALW) |=> br_taken); // R4
endmodule

// File: tb/cond_branch_unit_bench.sv
`timescale 1ns/1ps
module cond_branch_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 0, upd_is_flow = 0, rti_valid = 0, br_valid = 0, br_autoreg = 0;
  logic [3:0] alu_flags = 0, rti_flags = 0;
  logic [4:0] br_cond = 0;
  logic [3:0] flags;
  logic br_taken, addr_upd_en;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cond_branch_unit u_cond_branch_unit (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_is_flow(upd_is_flow),
    .alu_flags(alu_flags), .rti_valid(rti_valid), .rti_flags(rti_flags),
    .br_valid(br_valid), .br_cond(br_cond), .br_autoreg(br_autoreg),
    .flags(flags), .br_taken(br_taken), .addr_upd_en(addr_upd_en)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model(logic [3:0] f, int c);
    bit zr = f[0], ng = f[1], uo = f[2], so = f[3];
    case (c)
      0: return 1;          1: return 0;
      2: return zr;         3: return !zr;
      4: return ng;         5: return !ng;
      6: return uo;         7: return !uo;
      8: return so;         9: return !so;
      10: return zr;        11: return !zr;
      12: return !(uo|zr);  13: return !uo;
      14: return uo;        15: return uo|zr;
      16: return !((so^ng)|zr); 17: return !(so^ng);
      18: return so^ng;     19: return (so^ng)|zr;
      default: return 0;
    endcase
  endfunction

  task automatic alu_write(logic [3:0] f, logic flow);
    @(negedge clk);
    upd_valid = 1; upd_is_flow = flow; alu_flags = f;
    @(negedge clk);
    upd_valid = 0; upd_is_flow = 0;
  endtask

  task automatic branch(int c, logic ar);
    @(negedge clk);
    br_valid = 1; br_cond = 5'(c); br_autoreg = ar;
    @(negedge clk);
    br_valid = 0; br_autoreg = 0;
  endtask

  function automatic logic [3:0] cmp_flags(logic [15:0] d, logic [15:0] s);
    logic [15:0] r = d - s;
    logic [3:0] f;
    f[0] = (r == 0);
    f[1] = r[15];
    f[2] = (d < s);
    f[3] = (d[15] != s[15]) && (r[15] != d[15]);
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    check("R1 flags", flags, 0);
    check("R1 taken", br_taken, 0);
    check("R1 gate", addr_upd_en, 0);

    // R4 R5 R6 R7 R8 R9: full sweep of flags x codes x addressing bit
    for (int f = 0; f < 16; f++) begin
      alu_write(4'(f), 1'b0);
      check("R2 load", flags, f);
      for (int c = 0; c < 32; c++) begin
        for (int ar = 0; ar < 2; ar++) begin
          branch(c, 1'(ar));
          check(c < 10 ? "R4 taken" : c < 16 ? "R5 taken" : c < 20 ? "R6 taken" : "R7 taken",
                br_taken, model(4'(f), c));
          check("R8 gate", addr_upd_en, model(4'(f), c) && ar);
          @(negedge clk);
          check("R9 idle taken", br_taken, 0);
        end
      end
    end

    // R5 R6: compare semantics in 16-bit arithmetic
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] d = vals[i], s = vals[j];
        alu_write(cmp_flags(d, s), 1'b0);
        branch(10, 0); check("R5 eq", br_taken, d == s);
        branch(11, 0); check("R5 ne", br_taken, d != s);
        branch(12, 0); check("R5 ugt", br_taken, d > s);
        branch(13, 0); check("R5 uge", br_taken, d >= s);
        branch(14, 0); check("R5 ult", br_taken, d < s);
        branch(15, 0); check("R5 ule", br_taken, d <= s);
        branch(16, 0); check("R6 sgt", br_taken, $signed(d) > $signed(s));
        branch(17, 0); check("R6 sge", br_taken, $signed(d) >= $signed(s));
        branch(18, 0); check("R6 slt", br_taken, $signed(d) < $signed(s));
        branch(19, 0); check("R6 sle", br_taken, $signed(d) <= $signed(s));
      end
    end

    // R3: flow-control retire leaves flags alone
    alu_write(4'h3, 1'b0);
    alu_write(4'hc, 1'b1);
    check("R3 flow hold", flags, 4'h3);

    // R11: idle cycles hold
    repeat (5) @(negedge clk);
    check("R11 idle hold", flags, 4'h3);

    // R10: restore beats ALU update in same cycle
    @(negedge clk);
    rti_valid = 1; rti_flags = 4'ha; upd_valid = 1; alu_flags = 4'h5;
    @(negedge clk);
    rti_valid = 0; upd_valid = 0;
    check("R10 restore priority", flags, 4'ha);
    @(negedge clk);
    rti_valid = 1; rti_flags = 4'h6; upd_valid = 1; upd_is_flow = 1;
    @(negedge clk);
    rti_valid = 0; upd_valid = 0; upd_is_flow = 0;
    check("R10 restore alone", flags, 4'h6);

    // R1: reset mid-run clears state
    branch(0, 1);
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    check("R1 reset flags", flags, 0);
    check("R1 reset gate", addr_upd_en, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule